// File: doc/BRIEF.md
# DMA Tag Group Completion Tracker

This block keeps one outstanding-transfer counter for each of 32 DMA tag groups. Every issued command carries a 5-bit tag and bumps that group's counter. Every completion carrying the same tag lowers it. A group whose counter reads zero has nothing in flight and counts as complete. Transfers themselves are carried out elsewhere. The block only sees the issue and completion strobes.

Software selects which groups it cares about with a 32-bit query mask and chooses how a status read behaves with a 2-bit wait mode. It then requests a status read. An immediate read answers on the next cycle with the masked completion bits, which may all be zero; software then polls again. A wait-for-any read holds the requester stalled until at least one selected group is complete. A wait-for-all read holds it stalled until every selected group is complete. The answer is sampled in the first cycle the condition holds.

Top module: `tag_done_tracker`

## Requirements
- R1: Each of the 32 groups, addressed by the 5-bit tag, has a counter. An issue strobe raises the counter of its tag by one. A completion strobe lowers the counter of its tag by one. An issue and a completion on the same tag in the same cycle leave that counter unchanged.
- R2: Each counter is 6 bits wide and tracks up to 63 outstanding transfers for a group. The group stays incomplete until the last of them completes.
- R3: Bit n of the returned status is 1 exactly when mask bit n is 1 and group n has a zero count. All unmasked bits read 0.
- R4: A mask write loads the 32-bit mask on the next edge. A mode write loads the mode on the next edge. Mode codes are: 0 immediate, 1 wait-for-any, 2 wait-for-all. A mode write with code 3 is ignored and keeps the previous mode.
- R5: In immediate mode, rd_valid is high for one cycle, on the cycle after rd_req. rd_data carries the status sampled in the request cycle, and that status may be zero.
- R6: In wait-for-any mode, a read whose condition is false raises rd_stall from the next cycle. Once at least one masked group is complete, rd_stall falls and rd_valid rises on the following cycle. rd_data is then nonzero.
- R7: In wait-for-all mode, a read stalls until every masked group is complete. It then returns rd_data equal to the mask.
- R8: rd_stall and rd_valid are never high together. An rd_req raised while a read is stalled starts no second read and produces no extra rd_valid.
- R9: After reset, all counters are zero, the mask is zero, the mode is immediate, and rd_stall and rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | A command with issue_tag was issued |
| issue_tag | input | 5 | Tag of the issued command |
| cmpl_vld | input | 1 | A transfer with cmpl_tag finished |
| cmpl_tag | input | 5 | Tag of the finished transfer |
| mask_we | input | 1 | Load the query mask |
| mask_wdata | input | 32 | New query mask, bit n selects group n |
| mode_we | input | 1 | Load the wait mode |
| mode_wdata | input | 2 | New wait mode code |
| rd_req | input | 1 | Request a status read |
| rd_stall | output | 1 | A read is waiting for its condition |
| rd_valid | output | 1 | rd_data holds a read result this cycle |
| rd_data | output | 32 | Masked completion status |

## Verification
The assertions assume that no completion ever arrives for a group whose count is already zero, unless an issue for the same tag arrives in the same cycle. One of them checks this at the ports. The stimulus issues before it completes, and keeps every group below 64 outstanding transfers. The stimulus never starts a wait-for-any read with an empty mask, because such a read would stall forever. A wait-for-all read with an empty mask is allowed, and it returns zero at once.

// File: rtl/tagtrk_pkg.sv
package tagtrk_pkg;
    parameter int NUM_TAGS = 32;
    parameter int CNT_W    = 6;
    localparam int TAG_W   = $clog2(NUM_TAGS);

    typedef enum logic [1:0] {
        WAIT_NONE = 2'd0,
        WAIT_ANY  = 2'd1,
        WAIT_ALL  = 2'd2
    } wait_mode_e;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
    } tag_evt_t;

    function automatic logic mode_code_ok(input logic [1:0] code);
        return code != 2'd3;
    endfunction

    function automatic logic cond_met(input wait_mode_e mode,
                                      input logic [NUM_TAGS-1:0] status,
                                      input logic [NUM_TAGS-1:0] mask);
        case (mode)
            WAIT_ANY: return |status;
            WAIT_ALL: return status == mask;
            default:  return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/tag_count_bank.sv
module tag_count_bank
    import tagtrk_pkg::*;
#(
    parameter int N = NUM_TAGS,
    parameter int W = CNT_W
) (
    input  logic     clk,
    input  logic     rst,
    input  tag_evt_t up_evt,
    input  tag_evt_t dn_evt,
    output logic [N-1:0] idle
);
    for (genvar g = 0; g < N; g++) begin : g_cnt
        logic [W-1:0] cnt_q;
        logic up, dn;
        assign up = up_evt.vld && (up_evt.tag == TAG_W'(g));
        assign dn = dn_evt.vld && (dn_evt.tag == TAG_W'(g));
        always_ff @(posedge clk) begin
            if (rst)
                cnt_q <= '0;
            else if (up && !dn)
                cnt_q <= cnt_q + W'(1);
            else if (dn && !up)
                cnt_q <= cnt_q - W'(1);
        end
        assign idle[g] = (cnt_q == '0);
    end
endmodule

// File: rtl/tag_status_query.sv
module tag_status_query
    import tagtrk_pkg::*;
#(
    parameter int N = NUM_TAGS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] idle,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    input  logic         mode_we,
    input  logic [1:0]   mode_wdata,
    input  logic         rd_req,
    output logic         rd_stall,
    output logic         rd_valid,
    output logic [N-1:0] rd_data,
    output logic [N-1:0] mask_q,
    output wait_mode_e   mode_q
);
    logic         pend_q;
    logic         active;
    logic         release_now;
    logic [N-1:0] status;

    assign status      = mask_q & idle;
    assign active      = rd_req || pend_q;
    assign release_now = active && cond_met(mode_q, status, mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            mode_q <= WAIT_NONE;
        end else begin
            if (mask_we)
                mask_q <= mask_wdata;
            if (mode_we && mode_code_ok(mode_wdata))
                mode_q <= wait_mode_e'(mode_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (release_now) begin
                rd_valid <= 1'b1;
                rd_data  <= status;
                pend_q   <= 1'b0;
            end else if (active) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign rd_stall = pend_q;
endmodule

// File: rtl/tag_done_tracker.sv
module tag_done_tracker
    import tagtrk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        issue_vld,
    input  logic [4:0]  issue_tag,
    input  logic        cmpl_vld,
    input  logic [4:0]  cmpl_tag,
    input  logic        mask_we,
    input  logic [31:0] mask_wdata,
    input  logic        mode_we,
    input  logic [1:0]  mode_wdata,
    input  logic        rd_req,
    output logic        rd_stall,
    output logic        rd_valid,
    output logic [31:0] rd_data
);
    tag_evt_t              up_evt, dn_evt;
    logic [NUM_TAGS-1:0]   idle_vec;
    logic [NUM_TAGS-1:0]   mask_q;
    wait_mode_e            mode_q;

    assign up_evt = '{vld: issue_vld, tag: issue_tag};
    assign dn_evt = '{vld: cmpl_vld,  tag: cmpl_tag};

    tag_count_bank #(.N(NUM_TAGS), .W(CNT_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .up_evt (up_evt),
        .dn_evt (dn_evt),
        .idle   (idle_vec)
    );

    tag_status_query #(.N(NUM_TAGS)) u_query (
        .clk        (clk),
        .rst        (rst),
        .idle       (idle_vec),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .rd_req     (rd_req),
        .rd_stall   (rd_stall),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .mask_q     (mask_q),
        .mode_q     (mode_q)
    );
endmodule

// File: rtl/tag_done_tracker_chk.sv
module tag_done_tracker_chk
    import tagtrk_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        issue_vld,
    input logic [4:0]  issue_tag,
    input logic        cmpl_vld,
    input logic [4:0]  cmpl_tag,
    input logic        rd_stall,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic [31:0] mask_q,
    input wait_mode_e  mode_q,
    input logic [31:0] idle_vec
);
    // R8
    excl_out_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_stall, rd_valid}));

    // R6
    stall_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_stall) |-> rd_valid);

    // R3
    within_mask_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ((rd_data & ~$past(mask_q)) == 32'd0));

    // R6
    any_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(mode_q) == WAIT_ANY) |-> (rd_data != 32'd0));

    // R7
    all_full_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(mode_q) == WAIT_ALL) |-> (rd_data == $past(mask_q)));

    // R1
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (cmpl_vld && !(issue_vld && issue_tag == cmpl_tag)) |-> !idle_vec[cmpl_tag]);
endmodule

bind tag_done_tracker tag_done_tracker_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .issue_vld (issue_vld),
    .issue_tag (issue_tag),
    .cmpl_vld  (cmpl_vld),
    .cmpl_tag  (cmpl_tag),
    .rd_stall  (rd_stall),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .mask_q    (mask_q),
    .mode_q    (mode_q),
    .idle_vec  (idle_vec)
);

// File: tb/tag_done_tracker_bench.sv
module tag_done_tracker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_vld = 1'b0;
    logic [4:0]  issue_tag = '0;
    logic        cmpl_vld = 1'b0;
    logic [4:0]  cmpl_tag = '0;
    logic        mask_we = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic        mode_we = 1'b0;
    logic [1:0]  mode_wdata = '0;
    logic        rd_req = 1'b0;
    logic        rd_stall, rd_valid;
    logic [31:0] rd_data;

    int n_run = 0;
    int n_fail = 0;
    int n_valid = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #5 clk = ~clk;

    tag_done_tracker u_tag_done_tracker (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected results as reads complete
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            n_valid++;
            if (exp_q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL R8: unexpected rd_valid actual=%h expected=none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic issue(input logic [4:0] t);
        issue_vld = 1'b1; issue_tag = t; tick(); issue_vld = 1'b0;
    endtask

    task automatic cmpl(input logic [4:0] t);
        cmpl_vld = 1'b1; cmpl_tag = t; tick(); cmpl_vld = 1'b0;
    endtask

    task automatic set_mask(input logic [31:0] m);
        mask_we = 1'b1; mask_wdata = m; tick(); mask_we = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_we = 1'b1; mode_wdata = m; tick(); mode_we = 1'b0;
    endtask

    // driver: push expected item, then pulse the request
    task automatic start_read(input string req, input logic [31:0] exp);
        exp_q.push_back(exp); tag_q.push_back(req);
        rd_req = 1'b1; tick(); rd_req = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 4 && exp_q.size() != 0; i++) tick();
        check({req, " drained"}, 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        repeat (3) tick();
        check("R9 stall", {31'd0, rd_stall}, 32'd0);
        check("R9 valid", {31'd0, rd_valid}, 32'd0);
        rst = 1'b0;
        tick();
        // R9 mask reset to zero: immediate read returns 0
        start_read("R9 mask zero", 32'h0);
        check("R5 stall after imm", {31'd0, rd_stall}, 32'd0);
        drain("R9");

        // R3 R5 immediate, all idle
        set_mask(32'h0000_00A5);
        start_read("R3 all idle", 32'h0000_00A5);
        drain("R5");

        // R1 counts: tag3 x2, tag5 x1
        issue(5'd3); issue(5'd3); issue(5'd5);
        set_mask(32'h0000_00A8);
        start_read("R3 busy groups cleared", 32'h0000_0080);
        drain("R3");
        // R1 simultaneous issue+completion on tag 3 keeps count 2
        issue_vld = 1'b1; issue_tag = 5'd3; cmpl_vld = 1'b1; cmpl_tag = 5'd3;
        tick(); issue_vld = 1'b0; cmpl_vld = 1'b0;
        cmpl(5'd3);
        start_read("R1 same-cycle unchanged", 32'h0000_0080);
        drain("R1");

        // R5 immediate may return zero
        set_mask(32'h0000_0028);
        start_read("R5 zero status", 32'h0);
        drain("R5 zero");

        // R4 code 3 ignored: mode stays immediate
        set_mode(2'd3);
        start_read("R4 code3 ignored", 32'h0);
        drain("R4");

        // R6 wait-for-any
        set_mode(2'd1);
        start_read("R6 any release", 32'h0000_0020);
        tick(); tick();
        check("R6 stalled", {31'd0, rd_stall}, 32'd1);
        // R8 second request while stalled is ignored
        rd_req = 1'b1; tick(); rd_req = 1'b0;
        check("R8 still stalled", {31'd0, rd_stall}, 32'd1);
        cmpl(5'd5);
        check("R6 stall holds one cycle", {31'd0, rd_stall}, 32'd1);
        check("R6 no early valid", {31'd0, rd_valid}, 32'd0);
        tick();
        check("R6 stall dropped", {31'd0, rd_stall}, 32'd0);
        drain("R6");
        tick(); tick();
        check("R8 single valid", 32'(n_valid), 32'd7);

        // R7 wait-for-all: tag3 has 1 outstanding, tag5 idle
        set_mode(2'd2);
        issue(5'd5);
        start_read("R7 all release", 32'h0000_0028);
        cmpl(5'd3);
        tick();
        check("R7 waits for last group", {31'd0, rd_stall}, 32'd1);
        cmpl(5'd5);
        tick();
        drain("R7");

        // R2 63 outstanding on tag 31
        for (int i = 0; i < 63; i++) issue(5'd31);
        set_mode(2'd0);
        set_mask(32'h8000_0000);
        for (int i = 0; i < 62; i++) cmpl(5'd31);
        start_read("R2 one left busy", 32'h0);
        drain("R2a");
        cmpl(5'd31);
        start_read("R2 last completes", 32'h8000_0000);
        drain("R2b");

        // R7 full mask, everything idle
        set_mode(2'd2);
        set_mask(32'hFFFF_FFFF);
        start_read("R7 full mask", 32'hFFFF_FFFF);
        drain("R7 full");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule